// File: doc/BRIEF.md
# Masked-Write Link Client Register Block

This block is the register slave that sits beside a PCIe controller core and gives software a small control and event window over an APB-style bus. It holds a general control word, a hot-reset control word, a scratch debug word, a miscellaneous event status/mask pair, a legacy INTx status/mask pair and a read-only view of the link training state. From these it drives the control levels the link core needs. These are the training enable, the root-complex or endpoint selection and the enhanced enable mode. It also drives a qualified link-up flag and two aggregated interrupt lines.

Every writable control and mask word uses a per-bit enable. The upper 16 bits of the write word choose which of the lower 16 bits change. Software can therefore set or clear a single field in one bus write, without reading the register first. Event status is sticky and is cleared by writing ones. An event that arrives in the same cycle as its clear still leaves its bit set, so no event is lost.

Top module: `pcie_client_regs`

## Requirements
- R1: After reset the control, hot-reset and debug words read 0. The misc mask reads 0xFFFF and the INTx mask reads 0xF. Both status words read 0, and `sys_irq` and `intx_irq` are 0.
- R2: A write to control (0x000), debug (0x104), hot-reset (0x180), misc mask (0x024) or INTx mask (0x01C) changes bit i (i < register width) to `pwdata[i]` only when `pwdata[16+i]` is 1. All other bits keep their value. The write commits on the rising edge where `psel`, `penable` and `pwrite` are all high.
- R3: `ltssm_en` is 1 exactly when control bits [3:2] are 0b11. `rc_mode` equals control bit 6. `ep_mode` is 1 exactly when control bits [7:4] are all 0. `ltssm_enh` equals hot-reset bit 4.
- R4: A read of 0x300 returns the live training state in [5:0], the physical-layer up flag in bit 16 and the data-link up flag in bit 17, with all other bits 0. `link_up` is 1 one cycle after both flags are 1 and the state equals 0x11, and is 0 one cycle after any of these stops holding.
- R5: Misc status bit 1 is set on every edge where the data-link up flag differs from its value at the previous edge (the value before the first edge counts as 0). Bit 2 is set on every edge where `hot_reset_req` is 1. A read of 0x010 returns these bits, with all other bits 0.
- R6: A write to 0x010 clears each status bit whose `pwdata` bit in [15:0] is 1. A set event on the same edge wins over the clear.
- R7: A read of 0x008 returns in [3:0] the `intx_src` value sampled at the previous rising edge.
- R8: `sys_irq` is the OR of misc status AND NOT misc mask. `intx_irq` is the OR of INTx status AND NOT INTx mask. A mask bit of 1 blocks its source and a mask bit of 0 passes it.
- R9: A write to an unmapped offset, or to a read-only offset (0x008, 0x300), changes no register. A read of an unmapped offset returns 0.
- R10: A read of a writable register returns its value in the low bits, with the unused upper bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset |
| pwdata | input | 32 | Write word: enables in [31:16], values in [15:0] |
| prdata | output | 32 | Read word, valid while `psel` is high |
| ltssm_state | input | 6 | Current link training state |
| phy_link_up | input | 1 | Physical-layer link-up flag |
| dll_link_up | input | 1 | Data-link-layer link-up flag |
| hot_reset_req | input | 1 | Hot-reset or link-down reset request |
| intx_src | input | 4 | Legacy INTx source levels |
| ltssm_en | output | 1 | Link training enable |
| rc_mode | output | 1 | Root-complex mode selected |
| ep_mode | output | 1 | Endpoint mode selected |
| ltssm_enh | output | 1 | Enhanced training-enable mode |
| link_up | output | 1 | Qualified full link-up |
| sys_irq | output | 1 | Aggregated misc interrupt |
| intx_irq | output | 1 | Aggregated legacy interrupt |

## Verification
Register writes, status clears and event captures all commit on one rising edge. The control outputs and interrupt lines that derive from them are therefore due at the next falling edge. The bench drives each stimulus at a falling edge, lets one rising edge pass and samples at the falling edge after it. The qualified `link_up` flag and the INTx status word have one register stage after their inputs, so they are checked one full cycle after the input change. Read data is combinational during the access phase and is sampled just after `penable` rises.

// File: rtl/pcie_client_pkg.sv
package pcie_client_pkg;

    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam int HALF_W  = DATA_W / 2;
    localparam int N_INTX  = 4;
    localparam int STATE_W = 6;

    localparam logic [ADDR_W-1:0] OFS_CTRL     = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_INTX_ST  = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_MISC_ST  = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_INTX_MSK = 12'h01C;
    localparam logic [ADDR_W-1:0] OFS_MISC_MSK = 12'h024;
    localparam logic [ADDR_W-1:0] OFS_DEBUG    = 12'h104;
    localparam logic [ADDR_W-1:0] OFS_HOTRST   = 12'h180;
    localparam logic [ADDR_W-1:0] OFS_LTSSM    = 12'h300;

    localparam logic [STATE_W-1:0] STATE_ACTIVE = 6'h11;

    localparam int EVT_DLL_CHG = 1;
    localparam int EVT_RST_REQ = 2;

    localparam int PHY_UP_BIT = 16;
    localparam int DLL_UP_BIT = 17;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_INTX_ST,
        SEL_MISC_ST,
        SEL_INTX_MSK,
        SEL_MISC_MSK,
        SEL_DEBUG,
        SEL_HOTRST,
        SEL_LTSSM
    } reg_sel_e;

    typedef struct packed {
        logic [STATE_W-1:0] state;
        logic               phy_up;
        logic               dll_up;
    } link_obs_t;

    function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_CTRL:     s = SEL_CTRL;
            OFS_INTX_ST:  s = SEL_INTX_ST;
            OFS_MISC_ST:  s = SEL_MISC_ST;
            OFS_INTX_MSK: s = SEL_INTX_MSK;
            OFS_MISC_MSK: s = SEL_MISC_MSK;
            OFS_DEBUG:    s = SEL_DEBUG;
            OFS_HOTRST:   s = SEL_HOTRST;
            OFS_LTSSM:    s = SEL_LTSSM;
            default:      s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] ltssm_word(input link_obs_t o);
        logic [DATA_W-1:0] w;
        w = '0;
        w[STATE_W-1:0] = o.state;
        w[PHY_UP_BIT]  = o.phy_up;
        w[DLL_UP_BIT]  = o.dll_up;
        return w;
    endfunction

endpackage

// File: rtl/pcie_client_mreg.sv
module pcie_client_mreg #(
    parameter int           W       = 16,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [2*W-1:0] wdata,
    output logic [W-1:0]   q
);

    logic [W-1:0] en;
    logic [W-1:0] val;

    assign en  = wdata[2*W-1:W];
    assign val = wdata[W-1:0];

    always_ff @(posedge clk) begin
        if (rst)
            q <= RST_VAL;
        else if (we)
            q <= (q & ~en) | (val & en);
    end

    // R2: without a write strobe the word holds
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));

    for (genvar i = 0; i < W; i++) begin : g_bitchk
        // R2: a disabled bit keeps its old value
        a_r2_bit_keep: assert property (@(posedge clk) disable iff (rst)
            (we && !wdata[W+i]) |=> (q[i] == $past(q[i])));
        // R2: an enabled bit takes its value bit
        a_r2_bit_take: assert property (@(posedge clk) disable iff (rst)
            (we && wdata[W+i]) |=> (q[i] == $past(wdata[i])));
    end

endmodule

// File: rtl/pcie_client_evt.sv
module pcie_client_evt
    import pcie_client_pkg::*;
#(
    parameter int SW = HALF_W
) (
    input  logic          clk,
    input  logic          rst,
    input  link_obs_t     obs,
    input  logic          rst_req,
    input  logic          clr_we,
    input  logic [SW-1:0] clr_bits,
    output logic [SW-1:0] stat,
    output logic          link_up
);

    localparam logic [SW-1:0] IMPL = SW'((1 << EVT_DLL_CHG) | (1 << EVT_RST_REQ));

    logic          dll_q;
    logic          dll_chg;
    logic [SW-1:0] set_v;
    logic [SW-1:0] clr_v;

    assign dll_chg = obs.dll_up ^ dll_q;

    always_comb begin
        set_v = '0;
        set_v[EVT_DLL_CHG] = dll_chg;
        set_v[EVT_RST_REQ] = rst_req;
        clr_v = clr_we ? clr_bits : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dll_q   <= 1'b0;
            stat    <= '0;
            link_up <= 1'b0;
        end else begin
            dll_q   <= obs.dll_up;
            stat    <= ((stat & ~clr_v) | set_v) & IMPL;
            link_up <= obs.phy_up && obs.dll_up && (obs.state == STATE_ACTIVE);
        end
    end

    // R5: a data-link flag change is latched
    a_r5_chg_latched: assert property (@(posedge clk) disable iff (rst)
        dll_chg |=> stat[EVT_DLL_CHG]);
    // R5: a reset request is latched
    a_r5_req_latched: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> stat[EVT_RST_REQ]);
    // R6: a set bit stays set unless cleared
    a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
        (stat[EVT_DLL_CHG] && !(clr_we && clr_bits[EVT_DLL_CHG])) |=> stat[EVT_DLL_CHG]);
    // R6: clear without a concurrent event empties the bit
    a_r6_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_we && clr_bits[EVT_RST_REQ] && !rst_req) |=> !stat[EVT_RST_REQ]);
    // R4: link_up only after all three conditions held
    a_r4_qualified: assert property (@(posedge clk) disable iff (rst)
        link_up |-> $past(obs.phy_up && obs.dll_up && (obs.state == STATE_ACTIVE)));

endmodule

// File: rtl/pcie_client_intx.sv
module pcie_client_intx #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] src,
    input  logic [N-1:0] mask,
    output logic [N-1:0] st,
    output logic         irq
);

    logic [N-1:0] pass;

    for (genvar i = 0; i < N; i++) begin : g_gate
        assign pass[i] = st[i] & ~mask[i];
    end

    assign irq = |pass;

    always_ff @(posedge clk) begin
        if (rst)
            st <= '0;
        else
            st <= src;
    end

    // R7: status shows the previous-edge source levels
    a_r7_sample: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (st == $past(src)));
    // R8: a fully masked set never interrupts
    a_r8_all_masked: assert property (@(posedge clk) disable iff (rst)
        (&mask) |-> !irq);

endmodule

// File: rtl/pcie_client_regs.sv
module pcie_client_regs
    import pcie_client_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    input  logic [STATE_W-1:0] ltssm_state,
    input  logic              phy_link_up,
    input  logic              dll_link_up,
    input  logic              hot_reset_req,
    input  logic [N_INTX-1:0] intx_src,
    output logic              ltssm_en,
    output logic              rc_mode,
    output logic              ep_mode,
    output logic              ltssm_enh,
    output logic              link_up,
    output logic              sys_irq,
    output logic              intx_irq
);

    localparam logic [HALF_W-1:0] MASK_ALL = '1;
    localparam logic [N_INTX-1:0] INTX_ALL = '1;

    reg_sel_e          sel;
    logic              wr;
    link_obs_t         obs;

    logic [HALF_W-1:0] ctrl_q;
    logic [HALF_W-1:0] debug_q;
    logic [HALF_W-1:0] hotrst_q;
    logic [HALF_W-1:0] misc_msk_q;
    logic [N_INTX-1:0] intx_msk_q;
    logic [HALF_W-1:0] misc_st;
    logic [N_INTX-1:0] intx_st;

    assign sel = decode_offset(paddr);
    assign wr  = psel && penable && pwrite;

    assign obs.state  = ltssm_state;
    assign obs.phy_up = phy_link_up;
    assign obs.dll_up = dll_link_up;

    pcie_client_mreg #(.W(HALF_W), .RST_VAL('0)) u_ctrl (
        .clk(clk), .rst(rst), .we(wr && sel == SEL_CTRL), .wdata(pwdata), .q(ctrl_q));

    pcie_client_mreg #(.W(HALF_W), .RST_VAL('0)) u_debug (
        .clk(clk), .rst(rst), .we(wr && sel == SEL_DEBUG), .wdata(pwdata), .q(debug_q));

    pcie_client_mreg #(.W(HALF_W), .RST_VAL('0)) u_hotrst (
        .clk(clk), .rst(rst), .we(wr && sel == SEL_HOTRST), .wdata(pwdata), .q(hotrst_q));

    pcie_client_mreg #(.W(HALF_W), .RST_VAL(MASK_ALL)) u_misc_msk (
        .clk(clk), .rst(rst), .we(wr && sel == SEL_MISC_MSK), .wdata(pwdata), .q(misc_msk_q));

    pcie_client_mreg #(.W(N_INTX), .RST_VAL(INTX_ALL)) u_intx_msk (
        .clk(clk), .rst(rst), .we(wr && sel == SEL_INTX_MSK),
        .wdata({pwdata[HALF_W+N_INTX-1:HALF_W], pwdata[N_INTX-1:0]}), .q(intx_msk_q));

    pcie_client_evt #(.SW(HALF_W)) u_evt (
        .clk(clk), .rst(rst), .obs(obs), .rst_req(hot_reset_req),
        .clr_we(wr && sel == SEL_MISC_ST), .clr_bits(pwdata[HALF_W-1:0]),
        .stat(misc_st), .link_up(link_up));

    pcie_client_intx #(.N(N_INTX)) u_intx (
        .clk(clk), .rst(rst), .src(intx_src), .mask(intx_msk_q),
        .st(intx_st), .irq(intx_irq));

    assign sys_irq   = |(misc_st & ~misc_msk_q);
    assign ltssm_en  = (ctrl_q[3:2] == 2'b11);
    assign rc_mode   = ctrl_q[6];
    assign ep_mode   = (ctrl_q[7:4] == 4'b0000);
    assign ltssm_enh = hotrst_q[4];

    always_comb begin
        prdata = '0;
        if (psel) begin
            case (sel)
                SEL_CTRL:     prdata[HALF_W-1:0] = ctrl_q;
                SEL_DEBUG:    prdata[HALF_W-1:0] = debug_q;
                SEL_HOTRST:   prdata[HALF_W-1:0] = hotrst_q;
                SEL_MISC_MSK: prdata[HALF_W-1:0] = misc_msk_q;
                SEL_INTX_MSK: prdata[N_INTX-1:0] = intx_msk_q;
                SEL_MISC_ST:  prdata[HALF_W-1:0] = misc_st;
                SEL_INTX_ST:  prdata[N_INTX-1:0] = intx_st;
                SEL_LTSSM:    prdata             = ltssm_word(obs);
                default:      prdata             = '0;
            endcase
        end
    end

    // R9: unmapped reads return zero
    a_r9_unmapped_read: assert property (@(posedge clk) disable iff (rst)
        (psel && !pwrite && sel == SEL_NONE) |-> (prdata == '0));
    // R9: unmapped writes leave all writable words alone
    a_r9_unmapped_write: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == SEL_NONE) |=> ($stable(ctrl_q) && $stable(debug_q) && $stable(hotrst_q)
                                     && $stable(misc_msk_q) && $stable(intx_msk_q)));
    // R8: a fully masked event word never raises the system line
    a_r8_sys_masked: assert property (@(posedge clk) disable iff (rst)
        (&misc_msk_q) |-> !sys_irq);

endmodule

// File: tb/pcie_client_regs_test.sv
module pcie_client_regs_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [5:0]  ltssm_state = '0;
    logic        phy_link_up = 1'b0, dll_link_up = 1'b0, hot_reset_req = 1'b0;
    logic [3:0]  intx_src = '0;
    logic        ltssm_en, rc_mode, ep_mode, ltssm_enh, link_up, sys_irq, intx_irq;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pcie_client_regs uut (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .ltssm_state(ltssm_state), .phy_link_up(phy_link_up), .dll_link_up(dll_link_up),
        .hot_reset_req(hot_reset_req), .intx_src(intx_src),
        .ltssm_en(ltssm_en), .rc_mode(rc_mode), .ep_mode(ep_mode), .ltssm_enh(ltssm_enh),
        .link_up(link_up), .sys_irq(sys_irq), .intx_irq(intx_irq));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d, input bit with_req = 1'b0);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        if (with_req) hot_reset_req = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0; hot_reset_req = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        #1 d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_rd(a, d);
        check(tag, d, exp);
    endtask

    task automatic settle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rd_chk("R1 ctrl", 12'h000, 32'h0);
        rd_chk("R1 hotrst", 12'h180, 32'h0);
        rd_chk("R1 debug", 12'h104, 32'h0);
        rd_chk("R1 misc mask", 12'h024, 32'h0000_FFFF);
        rd_chk("R1 intx mask", 12'h01C, 32'h0000_000F);
        rd_chk("R1 misc st", 12'h010, 32'h0);
        rd_chk("R1 intx st", 12'h008, 32'h0);
        check("R1 sys_irq", {31'b0, sys_irq}, 32'h0);
        check("R1 intx_irq", {31'b0, intx_irq}, 32'h0);
        check("R3 reset ep_mode", {31'b0, ep_mode}, 32'h1);
        check("R3 reset ltssm_en", {31'b0, ltssm_en}, 32'h0);
    endtask

    task automatic t_masked();
        bus_wr(12'h000, 32'h000C_000C);
        rd_chk("R2 ctrl set 3:2", 12'h000, 32'h0000_000C);
        check("R3 ltssm_en on", {31'b0, ltssm_en}, 32'h1);
        bus_wr(12'h000, 32'h000C_0008);
        rd_chk("R2 ctrl disable code", 12'h000, 32'h0000_0008);
        check("R3 ltssm_en off", {31'b0, ltssm_en}, 32'h0);
        bus_wr(12'h000, 32'h0040_FFFF);
        rd_chk("R2 ctrl only bit6", 12'h000, 32'h0000_0048);
        check("R3 rc_mode", {31'b0, rc_mode}, 32'h1);
        check("R3 ep_mode off", {31'b0, ep_mode}, 32'h0);
        bus_wr(12'h000, 32'h0000_FFFF);
        rd_chk("R2 no enables no change", 12'h000, 32'h0000_0048);
        bus_wr(12'h000, 32'h00F0_0000);
        rd_chk("R2 clear 7:4", 12'h000, 32'h0000_0008);
        check("R3 ep_mode back", {31'b0, ep_mode}, 32'h1);
        bus_wr(12'h180, 32'h0010_0010);
        rd_chk("R2 hotrst", 12'h180, 32'h0000_0010);
        check("R3 ltssm_enh", {31'b0, ltssm_enh}, 32'h1);
        bus_wr(12'h104, 32'hFFFF_A5A5);
        bus_wr(12'h104, 32'h00FF_0000);
        rd_chk("R10 debug low half", 12'h104, 32'h0000_A500);
    endtask

    task automatic t_ltssm();
        @(negedge clk);
        ltssm_state = 6'h11; phy_link_up = 1'b1;
        settle();
        check("R4 partial no link_up", {31'b0, link_up}, 32'h0);
        rd_chk("R4 status word phy", 12'h300, 32'h0001_0011);
        @(negedge clk);
        dll_link_up = 1'b1;
        settle();
        check("R4 link_up", {31'b0, link_up}, 32'h1);
        rd_chk("R4 status word both", 12'h300, 32'h0003_0011);
        @(negedge clk);
        ltssm_state = 6'h10;
        settle();
        check("R4 state leaves", {31'b0, link_up}, 32'h0);
        @(negedge clk);
        ltssm_state = 6'h11;
        settle();
    endtask

    task automatic t_misc();
        rd_chk("R5 dll change latched", 12'h010, 32'h0000_0002);
        check("R8 misc masked", {31'b0, sys_irq}, 32'h0);
        bus_wr(12'h024, 32'h0002_0000);
        check("R8 sys_irq unmasked", {31'b0, sys_irq}, 32'h1);
        bus_wr(12'h010, 32'h0000_0004);
        rd_chk("R6 other bit kept", 12'h010, 32'h0000_0002);
        bus_wr(12'h010, 32'h0000_0002);
        rd_chk("R6 w1c clear", 12'h010, 32'h0);
        check("R8 sys_irq drops", {31'b0, sys_irq}, 32'h0);
        @(negedge clk); hot_reset_req = 1'b1;
        @(negedge clk); hot_reset_req = 1'b0;
        rd_chk("R5 reset req latched", 12'h010, 32'h0000_0004);
        check("R8 bit2 masked", {31'b0, sys_irq}, 32'h0);
        bus_wr(12'h024, 32'h0004_0000);
        check("R8 bit2 unmasked", {31'b0, sys_irq}, 32'h1);
        bus_wr(12'h010, 32'h0000_0004, 1'b1);
        rd_chk("R6 set wins over clear", 12'h010, 32'h0000_0004);
        bus_wr(12'h010, 32'hFFFF_0004);
        rd_chk("R6 clear bit2", 12'h010, 32'h0);
        @(negedge clk); dll_link_up = 1'b0;
        settle();
        check("R5 falling dll raises irq", {31'b0, sys_irq}, 32'h1);
        bus_wr(12'h010, 32'h0000_0002);
    endtask

    task automatic t_intx();
        @(negedge clk); intx_src = 4'b0101;
        settle();
        rd_chk("R7 intx status", 12'h008, 32'h0000_0005);
        check("R8 intx masked", {31'b0, intx_irq}, 32'h0);
        bus_wr(12'h01C, 32'h000F_000E);
        rd_chk("R2 intx mask", 12'h01C, 32'h0000_000E);
        check("R8 intx pass", {31'b0, intx_irq}, 32'h1);
        @(negedge clk); intx_src = 4'b0100;
        settle();
        check("R8 intx blocked src", {31'b0, intx_irq}, 32'h0);
        @(negedge clk); intx_src = 4'b0001;
        settle();
        check("R8 intx again", {31'b0, intx_irq}, 32'h1);
    endtask

    task automatic t_unmapped();
        bus_wr(12'h004, 32'hFFFF_FFFF);
        bus_wr(12'h001, 32'hFFFF_FFFF);
        rd_chk("R9 ctrl untouched", 12'h000, 32'h0000_0008);
        rd_chk("R9 read hole", 12'h004, 32'h0);
        rd_chk("R9 read far", 12'h200, 32'h0);
        bus_wr(12'h008, 32'hFFFF_FFFF);
        rd_chk("R9 intx st read-only", 12'h008, 32'h0000_0001);
        bus_wr(12'h300, 32'hFFFF_FFFF);
        rd_chk("R9 ltssm read-only", 12'h300, 32'h0001_0011);
        rd_chk("R9 misc mask untouched", 12'h024, 32'h0000_FFF9);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        t_reset();
        t_masked();
        t_ltssm();
        t_misc();
        t_intx();
        t_unmapped();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule